// File: doc/BRIEF.md
# Three-Channel Complementary Motor PWM

This block generates three complementary pulse-width modulated output pairs for a motor bridge. Each channel owns a timer, a period, a compare (match) value and a dead-time count. The timer runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Output A is active while the compared timer value is at or above the match value, and output B is its complement. Dead time keeps both outputs passive for a programmed number of clocks after every switch.

Software loads values through a simple write port into shadow registers. The shadow registers feed the working (functional) registers while a channel is stopped, and at the end of each PWM cycle while it runs, unless updates are frozen for that channel. Two global controls change the whole block. One inverts the sense of every B output. The other makes all three channels compare against channel 0's timer and period, for three-phase AC drive.

Top module: `pwmTrio`

## Requirements
- R1: With its run bit at 0 a channel's timer is held at 0 and its outputs sit at passive levels: A equals the polarity bit and B equals polarity XOR the B-inversion bit. With the run bit at 1 the timer counts from 0.
- R2: A write with select 0 loads the control word. Channel c uses bits 5c+0 run, 5c+1 center mode, 5c+2 polarity, 5c+3 dead-time enable and 5c+4 update freeze. Bit 15 is B inversion and bit 16 is AC mode. Every bit resets to 0.
- R3: In edge-aligned mode the timer steps 0,1,…,P and wraps to 0, so one cycle lasts P+1 clocks. A is active for P−M+1 clocks of each cycle and B for M. With M=0, A is always active. With M>P, A is never active.
- R4: In center-aligned mode the timer steps 0,1,…,P then P−1,…,1, so one cycle lasts 2P clocks. A is active for 2P−2M+1 clocks of each cycle.
- R5: With polarity 0, active means high. With polarity 1, active means low on both A and B.
- R6: With dead-time enable set and dead-time count D, each switch of the compare result holds both outputs passive for D clocks. With D=0, or with the enable clear, A and B are exact complements while running.
- R7: With B inversion set, each B output level is inverted relative to its normal level.
- R8: While running with update freeze 0, new shadow values take effect at the end of a PWM cycle. With update freeze 1, the working values stay unchanged as long as the timer runs.
- R9: While a channel is stopped, its shadow values are copied into the working registers whatever the freeze bit says.
- R10: With AC mode set, every channel compares against channel 0's timer, which runs on channel 0's period. Each channel keeps its own match value, dead time, polarity and run gating.
- R11: After reset every output is low.
- R12: Write select codes are 0 control, 1 period, 2 match and 3 dead time. The channel field picks channels 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Register select (R12) |
| wrCh | input | 2 | Channel select for period, match and dead time |
| wrData | input | 32 | Write data |
| outA | output | 3 | Output A per channel |
| outB | output | 3 | Output B per channel |

## Verification
The checker only assumes that the reset and write inputs are synchronous and free of unknowns. Its passive-level, overlap and complement properties must hold under any control sequence, including writes made while a channel runs. The stimulus keeps the channel field at 0 to 2 and changes run, mode and polarity only while every channel is stopped. The one exception is the freeze and match writes in the update test, which are made mid-run on purpose. This keeps each measured window periodic, so the counted active clocks match the closed-form values in R3 to R7.

// File: rtl/pwmTrioPkg.sv
package pwmTrioPkg;
  localparam int NCH      = 3;
  localparam int CH_BITS  = 5;
  localparam int INVB_BIT = 15;
  localparam int ACM_BIT  = 16;
  localparam int CTRL_W   = ACM_BIT + 1;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PER  = 2'd1,
    REG_MAT  = 2'd2,
    REG_DT   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NCH-1:0] run;
    logic [NCH-1:0] center;
    logic [NCH-1:0] pol;
    logic [NCH-1:0] dtEn;
    logic [NCH-1:0] load;
    logic           invB;
    logic           acMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/pwmTrioCtrl.sv
module pwmTrioCtrl
  import pwmTrioPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DT_W   = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [1:0]        wrCh,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NCH-1:0]    cycEnd,
  output ctrlStrobe_t       stb,
  output logic [CNT_W-1:0]  perSh [NCH],
  output logic [CNT_W-1:0]  matSh [NCH],
  output logic [DT_W-1:0]   dtSh  [NCH]
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [NCH-1:0]    updFreeze;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (wrEn && regSel_e'(wrSel) == REG_CTRL) begin
      ctrlReg <= wrData[CTRL_W-1:0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        perSh[i] <= '0;
        matSh[i] <= '0;
        dtSh[i]  <= '0;
      end else if (wrEn && wrCh == 2'(i)) begin
        case (regSel_e'(wrSel))
          REG_PER: perSh[i] <= wrData[CNT_W-1:0];
          REG_MAT: matSh[i] <= wrData[CNT_W-1:0];
          REG_DT:  dtSh[i]  <= wrData[DT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stb        = '0;
    updFreeze  = '0;
    stb.invB   = ctrlReg[INVB_BIT];
    stb.acMode = ctrlReg[ACM_BIT];
    for (int i = 0; i < NCH; i++) begin
      stb.run[i]    = ctrlReg[CH_BITS*i + 0];
      stb.center[i] = ctrlReg[CH_BITS*i + 1];
      stb.pol[i]    = ctrlReg[CH_BITS*i + 2];
      stb.dtEn[i]   = ctrlReg[CH_BITS*i + 3];
      updFreeze[i]  = ctrlReg[CH_BITS*i + 4];
      // stopped: copy every clock; running: copy at cycle end unless frozen
      stb.load[i] = !stb.run[i] ||
                    ((stb.acMode ? cycEnd[0] : cycEnd[i]) && !updFreeze[i]);
    end
  end
endmodule

// File: rtl/pwmTrioChan.sv
module pwmTrioChan #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             center,
  input  logic             dtEn,
  input  logic             load,
  input  logic [CNT_W-1:0] perSh,
  input  logic [CNT_W-1:0] matSh,
  input  logic [DT_W-1:0]  dtSh,
  input  logic [CNT_W-1:0] cmpTc,
  output logic [CNT_W-1:0] tc,
  output logic             cycEnd,
  output logic             actA,
  output logic             actB
);
  logic [CNT_W-1:0] perF, matF;
  logic [DT_W-1:0]  dtF, dtCnt;
  logic             down, raw, rawPrev, swap, blank;

  assign raw  = cmpTc >= matF;
  assign swap = raw != rawPrev;

  always_comb begin
    if (center) cycEnd = run && ((down && tc <= CNT_W'(1)) || perF == '0);
    else        cycEnd = run && (tc >= perF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perF <= '0; matF <= '0; dtF <= '0;
      tc <= '0; down <= 1'b0; rawPrev <= 1'b0; dtCnt <= '0;
    end else begin
      if (load) begin
        perF <= perSh;
        matF <= matSh;
        dtF  <= dtSh;
      end
      if (!run) begin
        tc <= '0; down <= 1'b0;
      end else if (!center) begin
        tc   <= (tc >= perF) ? '0 : tc + 1'b1;
        down <= 1'b0;
      end else if (perF == '0) begin
        tc <= '0; down <= 1'b0;
      end else if (!down) begin
        if (tc >= perF) begin
          tc <= tc - 1'b1; down <= 1'b1;
        end else begin
          tc <= tc + 1'b1;
        end
      end else if (tc <= CNT_W'(1)) begin
        tc <= '0; down <= 1'b0;
      end else begin
        tc <= tc - 1'b1;
      end
      rawPrev <= raw;
      if (swap)             dtCnt <= (dtF == '0) ? '0 : dtF - 1'b1;
      else if (dtCnt != '0) dtCnt <= dtCnt - 1'b1;
    end
  end

  // switch clock plus D-1 countdown clocks gives D blanked clocks
  assign blank = dtEn && (dtF != '0) && (swap || dtCnt != '0);
  assign actA  = run && raw && !blank;
  assign actB  = run && !raw && !blank;
endmodule

// File: rtl/pwmTrioData.sv
module pwmTrioData
  import pwmTrioPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          stb,
  input  logic [CNT_W-1:0]     perSh [NCH],
  input  logic [CNT_W-1:0]     matSh [NCH],
  input  logic [DT_W-1:0]      dtSh  [NCH],
  output logic [NCH-1:0]       cycEnd,
  output logic [NCH-1:0]       outA,
  output logic [NCH-1:0]       outB,
  output logic [NCH*CNT_W-1:0] tcFlat
);
  logic [CNT_W-1:0] tcArr [NCH];
  logic [NCH-1:0]   actA, actB;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] cmpTc;
    assign cmpTc = stb.acMode ? tcArr[0] : tcArr[i];

    pwmTrioChan #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .run    (stb.run[i]),
      .center (stb.center[i]),
      .dtEn   (stb.dtEn[i]),
      .load   (stb.load[i]),
      .perSh  (perSh[i]),
      .matSh  (matSh[i]),
      .dtSh   (dtSh[i]),
      .cmpTc  (cmpTc),
      .tc     (tcArr[i]),
      .cycEnd (cycEnd[i]),
      .actA   (actA[i]),
      .actB   (actB[i])
    );

    assign outA[i] = actA[i] ^ stb.pol[i];
    assign outB[i] = actB[i] ^ stb.pol[i] ^ stb.invB;
    assign tcFlat[i*CNT_W +: CNT_W] = tcArr[i];
  end
endmodule

// File: rtl/pwmTrio.sv
module pwmTrio
  import pwmTrioPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DT_W  = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           wrEn,
  input  logic [1:0]     wrSel,
  input  logic [1:0]     wrCh,
  input  logic [31:0]    wrData,
  output logic [NCH-1:0] outA,
  output logic [NCH-1:0] outB
);
  ctrlStrobe_t            stb;
  logic [CNT_W-1:0]       perSh [NCH];
  logic [CNT_W-1:0]       matSh [NCH];
  logic [DT_W-1:0]        dtSh  [NCH];
  logic [NCH-1:0]         cycEnd;
  logic [NCH*CNT_W-1:0]   tcFlat;

  pwmTrioCtrl #(.CNT_W(CNT_W), .DT_W(DT_W), .DATA_W(32)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrCh(wrCh),
    .wrData(wrData), .cycEnd(cycEnd), .stb(stb),
    .perSh(perSh), .matSh(matSh), .dtSh(dtSh)
  );

  pwmTrioData #(.CNT_W(CNT_W), .DT_W(DT_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb),
    .perSh(perSh), .matSh(matSh), .dtSh(dtSh),
    .cycEnd(cycEnd), .outA(outA), .outB(outB), .tcFlat(tcFlat)
  );
endmodule

// File: rtl/pwmTrioChk.sv
module pwmTrioChk
  import pwmTrioPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input ctrlStrobe_t          stb,
  input logic [NCH-1:0]       outA,
  input logic [NCH-1:0]       outB,
  input logic [NCH*CNT_W-1:0] tcFlat
);
  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic actA, actB;
    assign actA = outA[i] ^ stb.pol[i];
    assign actB = outB[i] ^ stb.pol[i] ^ stb.invB;

    // R1
    passive_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      !stb.run[i] |-> (outA[i] == stb.pol[i]) && (outB[i] == (stb.pol[i] ^ stb.invB)));

    // R1
    timer_start_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(stb.run[i]) |-> tcFlat[i*CNT_W +: CNT_W] == '0);

    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(actA && actB));

    // R6
    complement_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.run[i] && !stb.dtEn[i]) |-> (actA != actB));
  end
endmodule

bind pwmTrio pwmTrioChk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .outA(outA), .outB(outB), .tcFlat(tcFlat)
);

// File: tb/pwmTrio_bench.sv
module pwmTrio_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [1:0] wrCh = '0;
  logic [31:0] wrData = '0;
  logic [2:0] outA, outB;

  int checks = 0;
  int errors = 0;
  int cntA [3];
  int cntB [3];

  always #2 clk = ~clk;

  pwmTrio u_pwmTrio (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrCh(wrCh),
    .wrData(wrData), .outA(outA), .outB(outB)
  );

  typedef struct packed {
    logic        center;
    logic        pol;
    logic        dtEn;
    logic        invB;
    logic [15:0] per;
    logic [15:0] mat;
    logic [15:0] dt;
    logic [15:0] win;
    logic [15:0] expA;
    logic [15:0] expB;
  } vec_t;

  // expected counts are high-level clocks of outA/outB over win (4 cycles)
  localparam vec_t VECS [10] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd9, 16'd4, 16'd0, 16'd40, 16'd24, 16'd16},
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'd9, 16'd4, 16'd2, 16'd40, 16'd16, 16'd8},
    '{1'b1, 1'b0, 1'b0, 1'b0, 16'd8, 16'd3, 16'd0, 16'd64, 16'd44, 16'd20},
    '{1'b1, 1'b0, 1'b1, 1'b0, 16'd8, 16'd3, 16'd3, 16'd64, 16'd32, 16'd8},
    '{1'b0, 1'b1, 1'b0, 1'b0, 16'd9, 16'd4, 16'd0, 16'd40, 16'd16, 16'd24},
    '{1'b0, 1'b0, 1'b0, 1'b1, 16'd9, 16'd4, 16'd0, 16'd40, 16'd24, 16'd24},
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'd7, 16'd2, 16'd0, 16'd32, 16'd24, 16'd8},
    '{1'b0, 1'b0, 1'b1, 1'b0, 16'd5, 16'd0, 16'd2, 16'd24, 16'd24, 16'd0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'd5, 16'd7, 16'd0, 16'd24, 16'd0,  16'd24},
    '{1'b1, 1'b1, 1'b1, 1'b0, 16'd8, 16'd3, 16'd3, 16'd64, 16'd32, 16'd56}
  };

  function automatic string vecTag(int k);
    case (k)
      0: return "R3 edge";
      1: return "R6 edge dead time";
      2: return "R4 center";
      3: return "R4 R6 center dead time";
      4: return "R5 polarity";
      5: return "R7 B inversion";
      6: return "R6 zero dead time";
      7: return "R3 match zero";
      8: return "R3 match above period";
      default: return "R5 R6 center inverted";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [1:0] ch, logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrCh = ch; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(int win);
    for (int c = 0; c < 3; c++) begin cntA[c] = 0; cntB[c] = 0; end
    repeat (win) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) begin
        cntA[c] += int'(outA[c]);
        cntB[c] += int'(outB[c]);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R11 outputs low in reset and after release
    chk("R11 outA in reset", int'(outA), 0);
    rstN = 1'b1;
    idle(2);
    chk("R11 outA after reset", int'(outA), 0);
    chk("R11 outB after reset", int'(outB), 0);

    // vector loop: R2 R3 R4 R5 R6 R7 through control word layout
    for (int k = 0; k < 10; k++) begin
      int ch;
      logic [31:0] cw;
      ch = k % 3;
      wr(2'd0, 2'd0, 32'd0);
      wr(2'd1, 2'(ch), 32'(VECS[k].per));
      wr(2'd2, 2'(ch), 32'(VECS[k].mat));
      wr(2'd3, 2'(ch), 32'(VECS[k].dt));
      idle(3);
      cw = 32'({VECS[k].dtEn, VECS[k].pol, VECS[k].center, 1'b1}) << (5 * ch);
      cw[15] = VECS[k].invB;
      wr(2'd0, 2'd0, cw);
      idle(int'(VECS[k].win) / 2 + 6);
      measure(int'(VECS[k].win));
      chk({vecTag(k), " outA"}, cntA[ch], int'(VECS[k].expA));
      chk({vecTag(k), " outB"}, cntB[ch], int'(VECS[k].expB));
      for (int o = 0; o < 3; o++) begin
        if (o != ch) begin
          chk("R1 stopped channel outA", cntA[o], 0);
          chk("R1 stopped channel outB", cntB[o], VECS[k].invB ? int'(VECS[k].win) : 0);
        end
      end
    end

    // R8 shadow update at cycle end, then frozen
    wr(2'd0, 2'd0, 32'd0);
    wr(2'd1, 2'd0, 32'd9);
    wr(2'd2, 2'd0, 32'd4);
    wr(2'd3, 2'd0, 32'd0);
    idle(3);
    wr(2'd0, 2'd0, 32'h1);
    idle(25);
    wr(2'd2, 2'd0, 32'd6);
    idle(25);
    measure(40);
    chk("R8 update at cycle end", cntA[0], 16);
    wr(2'd0, 2'd0, 32'h11);
    wr(2'd2, 2'd0, 32'd2);
    idle(25);
    measure(40);
    chk("R8 frozen while running", cntA[0], 16);
    // R9 stopped copies shadow despite freeze
    wr(2'd0, 2'd0, 32'h10);
    idle(3);
    wr(2'd0, 2'd0, 32'h11);
    idle(25);
    measure(40);
    chk("R9 copy while stopped", cntA[0], 32);

    // R10 shared timer in AC mode
    wr(2'd0, 2'd0, 32'd0);
    wr(2'd1, 2'd0, 32'd9);
    wr(2'd2, 2'd0, 32'd4);
    wr(2'd1, 2'd1, 32'd5);
    wr(2'd2, 2'd1, 32'd6);
    wr(2'd3, 2'd1, 32'd0);
    idle(3);
    wr(2'd0, 2'd0, 32'h0000_0021);
    idle(25);
    measure(40);
    chk("R10 own timer ch1 outA", cntA[1], 0);
    wr(2'd0, 2'd0, 32'd0);
    idle(3);
    wr(2'd0, 2'd0, 32'h0001_0021);
    idle(25);
    measure(40);
    chk("R10 AC ch0 outA", cntA[0], 24);
    chk("R10 AC ch1 outA", cntA[1], 16);
    chk("R10 AC ch1 outB", cntB[1], 24);

    // R1 R5 R7 passive levels with polarity and inversion while stopped
    wr(2'd0, 2'd0, 32'h0000_1000);
    idle(3);
    chk("R1 passive outA pol", int'(outA[2]), 1);
    chk("R1 passive outB pol", int'(outB[2]), 1);
    wr(2'd0, 2'd0, 32'h0000_9000);
    idle(3);
    chk("R7 passive outB inverted", int'(outB[2]), 0);
    // R12 channel field 3 selects nothing: channel 0 match unchanged
    wr(2'd0, 2'd0, 32'd0);
    wr(2'd1, 2'd0, 32'd9);
    wr(2'd2, 2'd0, 32'd4);
    wr(2'd2, 2'd3, 32'd0);
    idle(3);
    wr(2'd0, 2'd0, 32'h1);
    idle(25);
    measure(40);
    chk("R12 channel 3 write ignored", cntA[0], 24);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule